// File: doc/BRIEF.md
# Machine/Supervisor Control Register File

This block holds the machine-level and supervisor-level control and status registers of a processor hart. It has one combinational read port and one write port, both selected by a 12-bit register number. Each stored register keeps only the bits software may change, so a write cannot set a bit outside the legal field set. Several supervisor registers are not stored separately. They are filtered windows onto the machine registers: the status view, and the pending and enable views gated by the delegation mask. A dirty-summary bit in the top bit of both status views is computed on every read from the floating-point and extension state fields.

Hardware interrupt sources come in on a pending vector, which is registered every cycle. A write to an unknown number, or to a number whose two top bits are both ones (the read-only address space), raises a write-illegal flag and changes nothing. A read of an unknown number raises a read-illegal flag and returns zero. The trap unit uses the raw status, pending, enable, delegation and vector outputs directly. A write takes effect at the next clock edge. A read in the same cycle still returns the old value.

Top module: `csrf_priv_regs`

## Requirements
- R1: After reset every readable register reads zero, except the machine trap vector, which reads MTVEC_RESET with bits 1:0 cleared, and the constants of R11.
- R2: A write to machine status (0x300) changes only bit 1, bit 3, bit 5, bit 7, bit 8, bits 12:11, bits 14:13 (FS), bit 17, bit 18 and bit 19. The extension field, bits 16:15 (XS), is writable only when HAS_EXT is 1. All other bits read zero, apart from bit 31.
- R3: Bit 31 of machine status (0x300) and of supervisor status (0x100) reads 1 exactly when FS == 3 or XS == 3.
- R4: Supervisor status (0x100) reads the machine status masked to bits 1, 5, 8, 14:13, 16:15 and 18, plus bit 31 per R3. A write through it changes only those bits of the machine status, and the R2 write mask still applies.
- R5: Software writes to the machine pending register (0x344) affect only bit 1 and bit 5. Bits 3, 7, 9 and 12 of the pending register follow the same bits of hw_pend one clock later. The other hw_pend bits are ignored.
- R6: The interrupt delegation register (0x303) keeps only bits 1, 5, 9 and 12. The machine enable register (0x304) keeps those bits plus bits 3 and 7. The exception delegation register (0x302) keeps only the bits of MEDELEG_MASK.
- R7: Supervisor pending (0x144) and supervisor enable (0x104) read as the machine register ANDed with the interrupt delegation register. A write through either changes only the delegated bits, and the machine write mask still applies.
- R8: A write to either trap vector (0x305 machine, 0x105 supervisor) stores the data with bits 1:0 forced to zero.
- R9: The two counter-enable registers (0x320, 0x321) keep only bits 2:0.
- R10: With HAS_FPU = 1, the combined float control register (0x003) holds the rounding mode in bits 7:5 above the accrued flags in bits 4:0. The flags alias (0x001) and the rounding-mode alias (0x002) read and write the same storage. With HAS_FPU = 0 all three are unknown numbers.
- R11: The ISA register (0xF10) reads 0x40000000 | ISA_EXT | bit 18 | bit 20. The hart-number register (0xF14) reads HART_ID. 0xF11 to 0xF13 and the counters 0xC00 to 0xC02 read zero. A write to any number with bits 11:10 == 3 raises wr_illegal and changes no state.
- R12: A read of an unknown number sets rd_illegal and returns zero. A write to an unknown number sets wr_illegal and changes no state.
- R13: A legal write is visible from the next clock edge. A read in the write cycle returns the old value. The scratch (0x140, 0x340), exception-PC (0x141, 0x341), cause (0x142, 0x342) and bad-address (0x143, 0x343) registers store all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Register number to write |
| wr_data | input | 32 | Write value |
| rd_addr | input | 12 | Register number to read |
| rd_data | output | 32 | Read value (combinational) |
| rd_illegal | output | 1 | Read number is unknown |
| wr_illegal | output | 1 | Write strobe hit an unknown or read-only number |
| hw_pend | input | 32 | Hardware interrupt pending sources |
| mstatus_o | output | 32 | Machine status, including the dirty-summary bit |
| mip_o | output | 32 | Machine pending bits, software and hardware merged |
| mie_o | output | 32 | Machine enable bits |
| mideleg_o | output | 32 | Interrupt delegation mask |
| medeleg_o | output | 32 | Exception delegation mask |
| mtvec_o | output | 32 | Machine trap vector |
| stvec_o | output | 32 | Supervisor trap vector |

## Verification
The bench targets the aliasing corners, because a design that stores the supervisor views separately would return stale values after a write through the other window. Examples are a supervisor enable write with a partial delegation mask, and a pending write that races a change in the hardware bits. The dirty summary is driven with FS at 1 and at 3, so a design that tests any set bit instead of all ones shows a false bit 31. Writes to the read-only space and to unknown numbers are checked for a raised flag and unchanged read-back, which catches a design that raises the flag but still commits the write. The float aliases are checked in both directions, which exposes swapped field packing.

// File: rtl/csrf_pkg.sv
package csrf_pkg;
    localparam int XLEN   = 32;
    localparam int ADDR_W = 12;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // register numbers
    localparam addr_t A_FFLAGS  = 12'h001;
    localparam addr_t A_FRM     = 12'h002;
    localparam addr_t A_FCSR    = 12'h003;
    localparam addr_t A_SSTATUS = 12'h100;
    localparam addr_t A_SIE     = 12'h104;
    localparam addr_t A_STVEC   = 12'h105;
    localparam addr_t A_SSCR    = 12'h140;
    localparam addr_t A_SEPC    = 12'h141;
    localparam addr_t A_SCAUSE  = 12'h142;
    localparam addr_t A_SBAD    = 12'h143;
    localparam addr_t A_SIP     = 12'h144;
    localparam addr_t A_MSTATUS = 12'h300;
    localparam addr_t A_MEDELEG = 12'h302;
    localparam addr_t A_MIDELEG = 12'h303;
    localparam addr_t A_MIE     = 12'h304;
    localparam addr_t A_MTVEC   = 12'h305;
    localparam addr_t A_UCNTEN  = 12'h320;
    localparam addr_t A_SCNTEN  = 12'h321;
    localparam addr_t A_MSCR    = 12'h340;
    localparam addr_t A_MEPC    = 12'h341;
    localparam addr_t A_MCAUSE  = 12'h342;
    localparam addr_t A_MBAD    = 12'h343;
    localparam addr_t A_MIP     = 12'h344;
    localparam addr_t A_CYCLE   = 12'hC00;
    localparam addr_t A_TIME    = 12'hC01;
    localparam addr_t A_INSTRET = 12'hC02;
    localparam addr_t A_ISA     = 12'hF10;
    localparam addr_t A_VENDOR  = 12'hF11;
    localparam addr_t A_ARCH    = 12'hF12;
    localparam addr_t A_IMPL    = 12'hF13;
    localparam addr_t A_HART    = 12'hF14;

    // status field positions
    localparam int ST_SIE  = 1;
    localparam int ST_MIE  = 3;
    localparam int ST_SPIE = 5;
    localparam int ST_MPIE = 7;
    localparam int ST_SPP  = 8;
    localparam int ST_MPP  = 11;
    localparam int ST_FS   = 13;
    localparam int ST_XS   = 15;
    localparam int ST_MPRV = 17;
    localparam int ST_PUM  = 18;
    localparam int ST_MXR  = 19;

    localparam word_t FS_MASK = word_t'(3) << ST_FS;
    localparam word_t XS_MASK = word_t'(3) << ST_XS;
    localparam word_t ST_WMASK =
        (word_t'(1) << ST_SIE) | (word_t'(1) << ST_MIE) | (word_t'(1) << ST_SPIE) |
        (word_t'(1) << ST_MPIE) | (word_t'(1) << ST_SPP) | (word_t'(3) << ST_MPP) |
        FS_MASK | (word_t'(1) << ST_MPRV) | (word_t'(1) << ST_PUM) | (word_t'(1) << ST_MXR);
    localparam word_t ST_SVIEW =
        (word_t'(1) << ST_SIE) | (word_t'(1) << ST_SPIE) | (word_t'(1) << ST_SPP) |
        FS_MASK | XS_MASK | (word_t'(1) << ST_PUM);

    // interrupt bit positions
    localparam int IRQ_SSW = 1;
    localparam int IRQ_MSW = 3;
    localparam int IRQ_STM = 5;
    localparam int IRQ_MTM = 7;
    localparam int IRQ_SEX = 9;
    localparam int IRQ_COP = 12;

    localparam word_t SW_PEND_MASK = (word_t'(1) << IRQ_SSW) | (word_t'(1) << IRQ_STM);
    localparam word_t DELEG_MASK   = SW_PEND_MASK | (word_t'(1) << IRQ_SEX) | (word_t'(1) << IRQ_COP);
    localparam word_t IE_MASK      = DELEG_MASK | (word_t'(1) << IRQ_MSW) | (word_t'(1) << IRQ_MTM);
    localparam word_t HW_PEND_MASK = (word_t'(1) << IRQ_MSW) | (word_t'(1) << IRQ_MTM) |
                                     (word_t'(1) << IRQ_SEX) | (word_t'(1) << IRQ_COP);

    typedef struct packed {
        word_t       mstatus;
        word_t       mip_sw;
        word_t       mip_hw;
        word_t       mie;
        word_t       mideleg;
        word_t       medeleg;
        word_t       mtvec;
        word_t       stvec;
        word_t       mepc;
        word_t       sepc;
        word_t       mscr;
        word_t       sscr;
        word_t       mcause;
        word_t       scause;
        word_t       mbad;
        word_t       sbad;
        logic [2:0]  ucnten;
        logic [2:0]  scnten;
        logic [4:0]  fflags;
        logic [2:0]  frm;
    } csr_state_t;

    function automatic logic st_dirty(input word_t st);
        return (st[ST_FS+1:ST_FS] == 2'b11) || (st[ST_XS+1:ST_XS] == 2'b11);
    endfunction
endpackage

// File: rtl/csrf_decode.sv
module csrf_decode
    import csrf_pkg::*;
#(
    parameter bit HAS_FPU = 1'b1
) (
    input  addr_t addr,
    output logic  known
);
    always_comb begin
        unique case (addr)
            A_FFLAGS, A_FRM, A_FCSR: known = HAS_FPU;
            A_SSTATUS, A_SIE, A_STVEC, A_SSCR, A_SEPC, A_SCAUSE, A_SBAD, A_SIP,
            A_MSTATUS, A_MEDELEG, A_MIDELEG, A_MIE, A_MTVEC, A_UCNTEN, A_SCNTEN,
            A_MSCR, A_MEPC, A_MCAUSE, A_MBAD, A_MIP,
            A_CYCLE, A_TIME, A_INSTRET,
            A_ISA, A_VENDOR, A_ARCH, A_IMPL, A_HART: known = 1'b1;
            default: known = 1'b0;
        endcase
    end
endmodule

// File: rtl/csrf_status_merge.sv
module csrf_status_merge
    import csrf_pkg::*;
#(
    parameter bit HAS_EXT = 1'b0
) (
    input  word_t cur,
    input  word_t wdata,
    input  logic  sview,
    output word_t nxt
);
    word_t wmask;
    word_t merged;

    generate
        if (HAS_EXT) begin : g_ext
            assign wmask = ST_WMASK | XS_MASK;
        end else begin : g_noext
            assign wmask = ST_WMASK;
        end
    endgenerate

    always_comb begin
        merged = sview ? ((cur & ~ST_SVIEW) | (wdata & ST_SVIEW)) : wdata;
        nxt    = (cur & ~wmask) | (merged & wmask);
    end
endmodule

// File: rtl/csrf_priv_regs.sv
module csrf_priv_regs
    import csrf_pkg::*;
#(
    parameter bit          HAS_FPU      = 1'b1,
    parameter bit          HAS_EXT      = 1'b0,
    parameter logic [31:0] HART_ID      = 32'd0,
    parameter logic [31:0] ISA_EXT      = 32'h0000_112D,
    parameter logic [31:0] MTVEC_RESET  = 32'h0000_0100,
    parameter logic [31:0] MEDELEG_MASK = 32'h0000_0FFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [11:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic [11:0] rd_addr,
    output logic [31:0] rd_data,
    output logic        rd_illegal,
    output logic        wr_illegal,
    input  logic [31:0] hw_pend,
    output logic [31:0] mstatus_o,
    output logic [31:0] mip_o,
    output logic [31:0] mie_o,
    output logic [31:0] mideleg_o,
    output logic [31:0] medeleg_o,
    output logic [31:0] mtvec_o,
    output logic [31:0] stvec_o
);
    localparam word_t ISA_VALUE = 32'h4000_0000 | ISA_EXT | (word_t'(1) << 18) | (word_t'(1) << 20);
    localparam word_t ALIGN4    = ~word_t'(3);

    csr_state_t s_q, s_d;
    logic  rd_known, wr_known, wr_ok;
    word_t st_next, mip_full, mst_rd, sst_rd;

    csrf_decode #(.HAS_FPU(HAS_FPU)) u_rd_dec (.addr(rd_addr), .known(rd_known));
    csrf_decode #(.HAS_FPU(HAS_FPU)) u_wr_dec (.addr(wr_addr), .known(wr_known));

    csrf_status_merge #(.HAS_EXT(HAS_EXT)) u_st_merge (
        .cur   (s_q.mstatus),
        .wdata (wr_data),
        .sview (wr_addr == A_SSTATUS),
        .nxt   (st_next)
    );

    assign wr_ok      = wr_known && (wr_addr[11:10] != 2'b11);
    assign wr_illegal = wr_en && !wr_ok;
    assign rd_illegal = !rd_known;
    assign mip_full   = s_q.mip_sw | s_q.mip_hw;
    assign mst_rd     = s_q.mstatus | {st_dirty(s_q.mstatus), 31'b0};
    assign sst_rd     = (s_q.mstatus & ST_SVIEW) | {st_dirty(s_q.mstatus), 31'b0};

    // next-state
    always_comb begin
        s_d        = s_q;
        s_d.mip_hw = hw_pend & HW_PEND_MASK;
        if (wr_en && wr_ok) begin
            unique case (wr_addr)
                A_FFLAGS:             s_d.fflags = wr_data[4:0];
                A_FRM:                s_d.frm    = wr_data[2:0];
                A_FCSR: begin
                    s_d.fflags = wr_data[4:0];
                    s_d.frm    = wr_data[7:5];
                end
                A_SSTATUS, A_MSTATUS: s_d.mstatus = st_next;
                A_SIE:     s_d.mie = ((s_q.mie & ~s_q.mideleg) | (wr_data & s_q.mideleg)) & IE_MASK;
                A_SIP:     s_d.mip_sw = ((mip_full & ~s_q.mideleg) | (wr_data & s_q.mideleg)) & SW_PEND_MASK;
                A_STVEC:   s_d.stvec   = wr_data & ALIGN4;
                A_MTVEC:   s_d.mtvec   = wr_data & ALIGN4;
                A_SSCR:    s_d.sscr    = wr_data;
                A_SEPC:    s_d.sepc    = wr_data;
                A_SCAUSE:  s_d.scause  = wr_data;
                A_SBAD:    s_d.sbad    = wr_data;
                A_MSCR:    s_d.mscr    = wr_data;
                A_MEPC:    s_d.mepc    = wr_data;
                A_MCAUSE:  s_d.mcause  = wr_data;
                A_MBAD:    s_d.mbad    = wr_data;
                A_MEDELEG: s_d.medeleg = wr_data & MEDELEG_MASK;
                A_MIDELEG: s_d.mideleg = wr_data & DELEG_MASK;
                A_MIE:     s_d.mie     = wr_data & IE_MASK;
                A_MIP:     s_d.mip_sw  = wr_data & SW_PEND_MASK;
                A_UCNTEN:  s_d.ucnten  = wr_data[2:0];
                A_SCNTEN:  s_d.scnten  = wr_data[2:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.mtvec <= MTVEC_RESET & ALIGN4;
        end else begin
            s_q <= s_d;
        end
    end

    // read port
    always_comb begin
        rd_data = '0;
        if (rd_known) begin
            unique case (rd_addr)
                A_FFLAGS:  rd_data = {27'b0, s_q.fflags};
                A_FRM:     rd_data = {29'b0, s_q.frm};
                A_FCSR:    rd_data = {24'b0, s_q.frm, s_q.fflags};
                A_SSTATUS: rd_data = sst_rd;
                A_SIE:     rd_data = s_q.mie & s_q.mideleg;
                A_SIP:     rd_data = mip_full & s_q.mideleg;
                A_STVEC:   rd_data = s_q.stvec;
                A_SSCR:    rd_data = s_q.sscr;
                A_SEPC:    rd_data = s_q.sepc;
                A_SCAUSE:  rd_data = s_q.scause;
                A_SBAD:    rd_data = s_q.sbad;
                A_MSTATUS: rd_data = mst_rd;
                A_MEDELEG: rd_data = s_q.medeleg;
                A_MIDELEG: rd_data = s_q.mideleg;
                A_MIE:     rd_data = s_q.mie;
                A_MIP:     rd_data = mip_full;
                A_MTVEC:   rd_data = s_q.mtvec;
                A_UCNTEN:  rd_data = {29'b0, s_q.ucnten};
                A_SCNTEN:  rd_data = {29'b0, s_q.scnten};
                A_MSCR:    rd_data = s_q.mscr;
                A_MEPC:    rd_data = s_q.mepc;
                A_MCAUSE:  rd_data = s_q.mcause;
                A_MBAD:    rd_data = s_q.mbad;
                A_ISA:     rd_data = ISA_VALUE;
                A_HART:    rd_data = HART_ID;
                default:   rd_data = '0;
            endcase
        end
    end

    assign mstatus_o = mst_rd;
    assign mip_o     = mip_full;
    assign mie_o     = s_q.mie;
    assign mideleg_o = s_q.mideleg;
    assign medeleg_o = s_q.medeleg;
    assign mtvec_o   = s_q.mtvec;
    assign stvec_o   = s_q.stvec;
endmodule

// File: rtl/csrf_priv_regs_chk.sv
module csrf_priv_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [11:0] wr_addr,
    input logic [31:0] wr_data,
    input logic [11:0] rd_addr,
    input logic [31:0] rd_data,
    input logic        wr_illegal,
    input logic [31:0] hw_pend,
    input logic [31:0] mstatus_o,
    input logic [31:0] mip_o,
    input logic [31:0] mie_o,
    input logic [31:0] mideleg_o,
    input logic [31:0] mtvec_o,
    input logic [31:0] stvec_o
);
    p_tvec_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_illegal && wr_addr == 12'h305) |=> (mtvec_o == {$past(wr_data[31:2]), 2'b00}));

    p_deleg_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_illegal && wr_addr == 12'h303) |=> (mideleg_o == ($past(wr_data) & 32'h0000_1222)));

    p_hw_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((mip_o & 32'h0000_1288) == ($past(hw_pend) & 32'h0000_1288)));

    p_illegal_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_illegal) |=> ($stable(mstatus_o) && $stable(mie_o) && $stable(mideleg_o)
                                   && $stable(mtvec_o) && $stable(stvec_o)));

    // R3 and R4: supervisor status read port agrees with the raw machine status
    p_sview_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 12'h100) |-> (rd_data == (mstatus_o & 32'h8005_E122)));

    p_sip_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 12'h144) |-> (rd_data == (mip_o & mideleg_o)));
endmodule

bind csrf_priv_regs csrf_priv_regs_chk u_csrf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .wr_illegal (wr_illegal),
    .hw_pend    (hw_pend),
    .mstatus_o  (mstatus_o),
    .mip_o      (mip_o),
    .mie_o      (mie_o),
    .mideleg_o  (mideleg_o),
    .mtvec_o    (mtvec_o),
    .stvec_o    (stvec_o)
);

// File: tb/test_csrf_priv_regs.sv
`timescale 1ns/1ps
module test_csrf_priv_regs;
    localparam logic [31:0] T_HART  = 32'd5;
    localparam logic [31:0] T_ISA   = 32'h0000_112D;
    localparam logic [31:0] T_TVEC  = 32'h0000_0100;
    localparam logic [31:0] T_EDELG = 32'h0000_0FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] hw_pend = '0;
    logic [31:0] rd_data, mstatus_o, mip_o, mie_o, mideleg_o, medeleg_o, mtvec_o, stvec_o;
    logic        rd_illegal, wr_illegal;

    logic        nf_wr_en = 1'b0;
    logic [11:0] nf_wr_addr = '0;
    logic [11:0] nf_rd_addr = '0;
    logic [31:0] nf_rd_data, nf_o0, nf_o1, nf_o2, nf_o3, nf_o4, nf_o5, nf_o6;
    logic        nf_rd_ill, nf_wr_ill;

    always #2 clk = ~clk;

    csrf_priv_regs #(.HART_ID(T_HART), .ISA_EXT(T_ISA), .MTVEC_RESET(T_TVEC),
                     .MEDELEG_MASK(T_EDELG)) i_csrf_priv_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_illegal(rd_illegal), .wr_illegal(wr_illegal),
        .hw_pend(hw_pend), .mstatus_o(mstatus_o), .mip_o(mip_o), .mie_o(mie_o),
        .mideleg_o(mideleg_o), .medeleg_o(medeleg_o), .mtvec_o(mtvec_o), .stvec_o(stvec_o));

    csrf_priv_regs #(.HAS_FPU(1'b0)) i_csrf_nofp (
        .clk(clk), .rst_n(rst_n), .wr_en(nf_wr_en), .wr_addr(nf_wr_addr), .wr_data(32'hFFFF_FFFF),
        .rd_addr(nf_rd_addr), .rd_data(nf_rd_data), .rd_illegal(nf_rd_ill), .wr_illegal(nf_wr_ill),
        .hw_pend(32'h0), .mstatus_o(nf_o0), .mip_o(nf_o1), .mie_o(nf_o2),
        .mideleg_o(nf_o3), .medeleg_o(nf_o4), .mtvec_o(nf_o5), .stvec_o(nf_o6));

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_st = 0, m_sw = 0, m_hw = 0, m_ie = 0, m_idl = 0, m_edl = 0;
    logic [31:0] m_mtv = T_TVEC, m_stv = 0, m_mepc = 0, m_sepc = 0, m_mscr = 0, m_sscr = 0;
    logic [31:0] m_mcau = 0, m_scau = 0, m_mbad = 0, m_sbad = 0;
    logic [2:0]  m_ucn = 0, m_scn = 0, m_frm = 0;
    logic [4:0]  m_ffl = 0;

    localparam logic [11:0] ADDRS [0:30] = '{
        12'h001, 12'h002, 12'h003, 12'h100, 12'h104, 12'h105, 12'h140, 12'h141,
        12'h142, 12'h143, 12'h144, 12'h300, 12'h302, 12'h303, 12'h304, 12'h305,
        12'h320, 12'h321, 12'h340, 12'h341, 12'h342, 12'h343, 12'h344, 12'hC00,
        12'hC01, 12'hC02, 12'hF10, 12'hF11, 12'hF12, 12'hF13, 12'hF14};

    function automatic bit is_known(input logic [11:0] a);
        foreach (ADDRS[i]) if (ADDRS[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit is_writable(input logic [11:0] a);
        return is_known(a) && (a[11:10] != 2'b11);
    endfunction

    function automatic logic [31:0] sd_bit(input logic [31:0] st);
        return ((st[14:13] == 2'b11) || (st[16:15] == 2'b11)) ? 32'h8000_0000 : 32'h0;
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        case (a)
            12'h001, 12'h002, 12'h003: return "R10";
            12'h100:                   return "R4";
            12'h300:                   return "R2";
            12'h104, 12'h144:          return "R7";
            12'h344:                   return "R5";
            12'h302, 12'h303, 12'h304: return "R6";
            12'h105, 12'h305:          return "R8";
            12'h320, 12'h321:          return "R9";
            default: return is_known(a) ? (a[11:10] == 2'b11 ? "R11" : "R13") : "R12";
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            12'h001: return {27'b0, m_ffl};
            12'h002: return {29'b0, m_frm};
            12'h003: return {24'b0, m_frm, m_ffl};
            12'h100: return (m_st & 32'h0005_E122) | sd_bit(m_st);
            12'h104: return m_ie & m_idl;
            12'h105: return m_stv;
            12'h140: return m_sscr;
            12'h141: return m_sepc;
            12'h142: return m_scau;
            12'h143: return m_sbad;
            12'h144: return (m_sw | m_hw) & m_idl;
            12'h300: return m_st | sd_bit(m_st);
            12'h302: return m_edl;
            12'h303: return m_idl;
            12'h304: return m_ie;
            12'h305: return m_mtv;
            12'h320: return {29'b0, m_ucn};
            12'h321: return {29'b0, m_scn};
            12'h340: return m_mscr;
            12'h341: return m_mepc;
            12'h342: return m_mcau;
            12'h343: return m_mbad;
            12'h344: return m_sw | m_hw;
            12'hF10: return 32'h4000_0000 | T_ISA | 32'h0014_0000;
            12'hF14: return T_HART;
            default: return 32'h0;
        endcase
    endfunction

    task automatic st_write(input logic [31:0] v);
        m_st = (m_st & ~32'h000E_79AA) | (v & 32'h000E_79AA);
    endtask

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        case (a)
            12'h001: m_ffl = d[4:0];
            12'h002: m_frm = d[2:0];
            12'h003: begin m_ffl = d[4:0]; m_frm = d[7:5]; end
            12'h100: st_write((m_st & ~32'h0005_E122) | (d & 32'h0005_E122));
            12'h104: m_ie = ((m_ie & ~m_idl) | (d & m_idl)) & 32'h0000_12AA;
            12'h105: m_stv = d & 32'hFFFF_FFFC;
            12'h140: m_sscr = d;
            12'h141: m_sepc = d;
            12'h142: m_scau = d;
            12'h143: m_sbad = d;
            12'h144: m_sw = (((m_sw | m_hw) & ~m_idl) | (d & m_idl)) & 32'h0000_0022;
            12'h300: st_write(d);
            12'h302: m_edl = d & T_EDELG;
            12'h303: m_idl = d & 32'h0000_1222;
            12'h304: m_ie = d & 32'h0000_12AA;
            12'h305: m_mtv = d & 32'hFFFF_FFFC;
            12'h320: m_ucn = d[2:0];
            12'h321: m_scn = d[2:0];
            12'h340: m_mscr = d;
            12'h341: m_mepc = d;
            12'h342: m_mcau = d;
            12'h343: m_mbad = d;
            12'h344: m_sw = d & 32'h0000_0022;
            default: ;
        endcase
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic [31:0] hw);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; hw_pend = hw; rd_addr = a;
        #1;
        chk({31'b0, wr_illegal}, {31'b0, !is_writable(a)}, {tag_of(a), " wr_illegal"});
        chk(rd_data, model_read(a), "R13 old value in write cycle");
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (is_writable(a)) model_write(a, d);
        m_hw = hw & 32'h0000_1288;
    endtask

    task automatic check_read(input logic [11:0] a, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(rd_data, model_read(a), tag);
        chk({31'b0, rd_illegal}, {31'b0, !is_known(a)}, {tag, " rd_illegal"});
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R11 constants
        foreach (ADDRS[i]) check_read(ADDRS[i], ADDRS[i][11:10] == 2'b11 ? "R11 constant" : "R1 reset");
        chk(mtvec_o, T_TVEC, "R1 mtvec_o reset");

        // R2, R3: status write mask and dirty summary
        do_write(12'h300, 32'hFFFF_FFFF, 32'h0);
        check_read(12'h300, "R2 status mask");
        chk(mstatus_o, 32'h800E_79AA, "R3 dirty bit set with FS=3");
        check_read(12'h100, "R4 status view");
        do_write(12'h300, 32'h0000_2000, 32'h0);
        check_read(12'h300, "R3 no dirty with FS=1");
        // R4 write through supervisor view
        do_write(12'h300, 32'h0, 32'h0);
        do_write(12'h100, 32'hFFFF_FFFF, 32'h0);
        check_read(12'h300, "R4 supervisor write only touches view bits");
        chk(mstatus_o, 32'h8004_6122, "R4 raw status after view write");

        // R5 pending: software bits and hardware mirror
        do_write(12'h344, 32'hFFFF_FFFF, 32'h0);
        check_read(12'h344, "R5 software pending bits");
        do_write(12'h340, 32'h1234_5678, 32'hFFFF_FFFF);
        check_read(12'h344, "R5 hardware pending mirror");
        chk(mip_o, 32'h0000_12AA, "R5 raw pending");

        // R6 masks
        do_write(12'h303, 32'hFFFF_FFFF, 32'h0);
        check_read(12'h303, "R6 interrupt delegation mask");
        do_write(12'h304, 32'hFFFF_FFFF, 32'h0);
        check_read(12'h304, "R6 enable mask");
        do_write(12'h302, 32'hFFFF_FFFF, 32'h0);
        check_read(12'h302, "R6 exception delegation mask");

        // R7 partial delegation
        do_write(12'h303, 32'h0000_0002, 32'h0);
        do_write(12'h104, 32'h0, 32'h0);
        check_read(12'h304, "R7 enable after supervisor clear");
        check_read(12'h104, "R7 supervisor enable view");
        do_write(12'h344, 32'h0000_0020, 32'h0);
        do_write(12'h144, 32'hFFFF_FFFF, 32'h0000_0200);
        check_read(12'h344, "R7 pending after supervisor write");
        check_read(12'h144, "R7 supervisor pending view");

        // R8 vectors, R9 counter enables
        do_write(12'h305, 32'hFFFF_FFFF, 32'h0);
        check_read(12'h305, "R8 machine vector alignment");
        do_write(12'h105, 32'h8000_0003, 32'h0);
        check_read(12'h105, "R8 supervisor vector alignment");
        do_write(12'h320, 32'hFFFF_FFFF, 32'h0);
        check_read(12'h320, "R9 user counter enable");
        do_write(12'h321, 32'hFFFF_FFF8, 32'h0);
        check_read(12'h321, "R9 supervisor counter enable");

        // R10 float aliases
        do_write(12'h003, 32'h0000_00FF, 32'h0);
        check_read(12'h001, "R10 flags alias");
        check_read(12'h002, "R10 rounding alias");
        do_write(12'h002, 32'h0000_0002, 32'h0);
        check_read(12'h003, "R10 combined after rounding write");
        do_write(12'h001, 32'h0000_0003, 32'h0);
        check_read(12'h003, "R10 combined after flags write");

        // R11 read-only writes, R12 unknown numbers
        do_write(12'hF14, 32'hFFFF_FFFF, 32'h0);
        check_read(12'hF14, "R11 hart number after write");
        do_write(12'hC00, 32'hFFFF_FFFF, 32'h0);
        check_read(12'hC00, "R11 counter stub");
        do_write(12'h7FF, 32'hFFFF_FFFF, 32'h0);
        check_read(12'h7FF, "R12 unknown read");
        check_read(12'h300, "R12 state kept after unknown write");

        // R10 no float unit
        @(negedge clk);
        nf_rd_addr = 12'h003; nf_wr_en = 1'b1; nf_wr_addr = 12'h001;
        #1;
        chk({31'b0, nf_rd_ill}, 32'h1, "R10 float register unknown without unit");
        chk(nf_rd_data, 32'h0, "R10 float read zero without unit");
        chk({31'b0, nf_wr_ill}, 32'h1, "R10 float write illegal without unit");
        @(posedge clk);
        #1 nf_wr_en = 1'b0;

        // constrained random
        void'($urandom(32'd4242));
        for (int k = 0; k < 400; k++) begin
            logic [11:0] a;
            logic [31:0] d;
            logic [31:0] hw;
            if (($urandom % 5) == 0) a = 12'($urandom);
            else a = ADDRS[$urandom % 31];
            d  = $urandom;
            hw = $urandom;
            do_write(a, d, hw);
            check_read(a, {tag_of(a), " random read-back"});
            if ((k % 8) == 0) check_read(12'h100, "R4 random view");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule